// File: doc/BRIEF.md
# Hash Message Padding Unit

This block sits in front of a SHA-1 style compression engine and turns a byte stream into the padded sequence of 32-bit words that the engine consumes. Message bytes arrive one per handshake, together with a marker on the final beat. They leave unchanged, packed big-endian into words. After the message the block adds a single one bit and then zero bits. It closes with the 64-bit length of the message, counted in bits. The output forms 512-bit blocks of sixteen words.

The block decides for itself whether the marker byte, the zero fill and the length field still fit in the block being filled. If they do not, it zero-fills that block and opens a further one for the length. Both sides use valid/ready handshakes. Each output word carries a flag for the end of its block and a flag for the end of the padded message. A final input beat can carry no byte, so an empty message can be presented.

Top module: `sha1_msg_padder`

## Requirements
- R1: Message bytes appear unchanged on `out_word`, four per word, the earliest byte in bits 31:24 and the latest in bits 7:0.
- R2: The byte that follows the last message byte in the output stream is 0x80, so the appended one bit is the most significant bit of that byte.
- R3: After the 0x80 byte, zero bytes follow until byte offset 56 of the current 64-byte block is reached.
- R4: Byte offsets 56 to 63 of the final block hold the message length in bits as a 64-bit value, most significant byte first.
- R5: When the message length modulo 64 is 56 or more, the current block is completed with the 0x80 byte and zeros, and one further block of zeros plus the length field follows.
- R6: A beat with `in_last`=1 and `in_nobyte`=1 that comes as the first beat of a message yields one block: 0x80000000 in the first word, zeros in words 1 to 15, and a length of zero.
- R7: `out_blk_end` is 1 exactly on every sixteenth output word. `out_msg_end` is 1 only on the last word of the final block of each message, and it is never 1 without `out_blk_end`.
- R8: The bit count starts from zero for every message, so the length field of a message does not depend on earlier messages.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_word` and both flags hold their values into the next cycle.
- R10: From the cycle after the last beat of a message is accepted until that message's length word has been produced, `in_ready` is 0.
- R11: A beat with `in_nobyte`=1 and `in_last`=0 is accepted and adds no byte to the message or to its length.
- R12: In the cycle after reset is applied, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block takes the input beat at this edge |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat ends the message |
| in_nobyte | input | 1 | Beat carries no byte |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 32 | Padded message word, big-endian bytes |
| out_blk_end | output | 1 | Word is the sixteenth word of a block |
| out_msg_end | output | 1 | Word is the last word of the padded message |

## Verification
The bench builds the block with its default 64-byte block, so every boundary of the padding rule is in reach with short messages. The chosen lengths are 0, 3, 55, 56, 63, 64, 119, 120 and 200 bytes. They fill the tail exactly, miss it by one byte, force an extra block, end on a word boundary and end off one. A throttled `out_ready` pattern holds words back for several cycles, which exercises holding and the stall of the input side. Gap beats without a byte are placed inside some messages.

// File: rtl/sha1_pad_pkg.sv
package sha1_pad_pkg;

    localparam int WORD_BYTES = 4;
    localparam int LEN_BYTES  = 8;
    localparam logic [7:0] MARK_BYTE = 8'h80;

    typedef enum logic [1:0] {
        PS_DATA,
        PS_MARK,
        PS_FILL,
        PS_LEN
    } pad_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic        blk_end;
        logic        msg_end;
    } out_word_t;

    // Byte idx of the length field, idx 0 being the most significant.
    function automatic logic [7:0] len_byte(input logic [63:0] bits, input logic [2:0] idx);
        return bits[(7 - int'(idx)) * 8 +: 8];
    endfunction

endpackage

// File: rtl/sha1_pad_seq.sv
module sha1_pad_seq
    import sha1_pad_pkg::*;
#(
    parameter int BLOCK_BYTES = 64,
    localparam int POS_W = $clog2(BLOCK_BYTES),
    localparam int FILL_POS = BLOCK_BYTES - LEN_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_nobyte,
    output logic             in_ready,
    input  logic             can_take,
    input  logic [POS_W-1:0] blk_pos,
    output logic             b_valid,
    output logic [7:0]       b_data,
    output logic             b_msg_end
);

    pad_state_e  state;
    logic [63:0] bit_cnt;
    logic [2:0]  len_idx;
    logic        accept;
    logic        at_tail;

    assign at_tail = (blk_pos == POS_W'(FILL_POS));
    assign accept  = in_valid && in_ready;

    always_comb begin
        in_ready  = (state == PS_DATA) && can_take;
        b_valid   = 1'b0;
        b_data    = in_data;
        b_msg_end = 1'b0;
        case (state)
            PS_DATA: b_valid = accept && !in_nobyte;
            PS_MARK: begin
                b_valid = can_take;
                b_data  = MARK_BYTE;
            end
            PS_FILL: begin
                b_valid = can_take && !at_tail;
                b_data  = 8'h00;
            end
            PS_LEN: begin
                b_valid   = can_take;
                b_data    = len_byte(bit_cnt, len_idx);
                b_msg_end = (len_idx == 3'(LEN_BYTES - 1));
            end
            default: b_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_DATA;
            bit_cnt <= '0;
            len_idx <= '0;
        end else begin
            case (state)
                PS_DATA: if (accept) begin
                    if (!in_nobyte) bit_cnt <= bit_cnt + 64'd8;
                    if (in_last)    state   <= PS_MARK;
                end
                PS_MARK: if (can_take) state <= PS_FILL;
                PS_FILL: if (at_tail)  state <= PS_LEN;
                PS_LEN: if (can_take) begin
                    if (len_idx == 3'(LEN_BYTES - 1)) begin
                        state   <= PS_DATA;
                        bit_cnt <= '0;
                        len_idx <= '0;
                    end else begin
                        len_idx <= len_idx + 3'd1;
                    end
                end
                default: state <= PS_DATA;
            endcase
        end
    end

endmodule

// File: rtl/sha1_pad_pack.sv
module sha1_pad_pack
    import sha1_pad_pkg::*;
#(
    parameter int BLOCK_BYTES = 64,
    localparam int POS_W = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             b_valid,
    input  logic [7:0]       b_data,
    input  logic             b_msg_end,
    input  logic             out_ready,
    output logic             can_take,
    output logic [POS_W-1:0] blk_pos,
    output logic             out_valid,
    output out_word_t        out_q
);

    logic [23:0] acc;
    logic        word_done;

    assign can_take  = !out_valid || out_ready;
    assign word_done = (blk_pos[1:0] == 2'(WORD_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            blk_pos   <= '0;
            acc       <= '0;
            out_q     <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (b_valid) begin
                acc     <= {acc[15:0], b_data};
                blk_pos <= blk_pos + 1'b1;
                if (word_done) begin
                    out_valid     <= 1'b1;
                    out_q.data    <= {acc, b_data};
                    out_q.blk_end <= (blk_pos == POS_W'(BLOCK_BYTES - 1));
                    out_q.msg_end <= b_msg_end;
                end
            end
        end
    end

endmodule

// File: rtl/sha1_msg_padder.sv
module sha1_msg_padder
    import sha1_pad_pkg::*;
#(
    parameter int BLOCK_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_nobyte,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic        out_blk_end,
    output logic        out_msg_end
);

    localparam int POS_W = $clog2(BLOCK_BYTES);

    logic             can_take;
    logic [POS_W-1:0] blk_pos;
    logic             b_valid;
    logic [7:0]       b_data;
    logic             b_msg_end;
    out_word_t        out_q;

    sha1_pad_seq #(.BLOCK_BYTES(BLOCK_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_nobyte (in_nobyte),
        .in_ready  (in_ready),
        .can_take  (can_take),
        .blk_pos   (blk_pos),
        .b_valid   (b_valid),
        .b_data    (b_data),
        .b_msg_end (b_msg_end)
    );

    sha1_pad_pack #(.BLOCK_BYTES(BLOCK_BYTES)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .b_valid   (b_valid),
        .b_data    (b_data),
        .b_msg_end (b_msg_end),
        .out_ready (out_ready),
        .can_take  (can_take),
        .blk_pos   (blk_pos),
        .out_valid (out_valid),
        .out_q     (out_q)
    );

    assign out_word    = out_q.data;
    assign out_blk_end = out_q.blk_end;
    assign out_msg_end = out_q.msg_end;

endmodule

// File: rtl/sha1_msg_padder_chk.sv
module sha1_msg_padder_chk #(
    parameter int BLOCK_BYTES = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic        out_blk_end,
    input logic        out_msg_end
);

    localparam int WORDS  = BLOCK_BYTES / 4;
    localparam int WCNT_W = $clog2(WORDS);

    logic [WCNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) wcnt <= '0;
        else if (out_valid && out_ready) wcnt <= wcnt + 1'b1;
    end

    a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)
            && $stable(out_blk_end) && $stable(out_msg_end)));

    a_r7_msg_end_on_block_end: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_msg_end) |-> out_blk_end);

    a_r7_block_end_every_sixteenth: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_blk_end == (wcnt == WCNT_W'(WORDS - 1))));

    a_r10_stall_after_last: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

endmodule

bind sha1_msg_padder sha1_msg_padder_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_last     (in_last),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .out_blk_end (out_blk_end),
    .out_msg_end (out_msg_end)
);

// File: tb/tb_sha1_msg_padder.sv
`timescale 1ns/1ps
module tb_sha1_msg_padder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_nobyte = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic        out_blk_end;
    logic        out_msg_end;

    always #2.5 clk = ~clk;

    sha1_msg_padder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_nobyte(in_nobyte),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_blk_end(out_blk_end), .out_msg_end(out_msg_end)
    );

    typedef struct {
        logic [31:0] w;
        logic        be;
        logic        me;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  msg_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          held = 1'b0;
    logic [33:0] held_v;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Behavioural padding model: byte list, then words.
    task automatic build_expected(input int msgno, input bit gap);
        logic [7:0] p[$];
        longint     bits;
        int         n, nw, nblk;
        bit         extra;
        p = msg_q;
        n = msg_q.size();
        p.push_back(8'h80);
        while ((p.size() % 64) != 56) p.push_back(8'h00);
        bits = longint'(n) * 8;
        for (int i = 0; i < 8; i++) p.push_back(8'(bits >> (56 - 8 * i)));
        nw    = p.size() / 4;
        nblk  = nw / 16;
        extra = (n % 64) >= 56;
        for (int k = 0; k < nw; k++) begin
            exp_t e;
            e.w  = {p[4*k], p[4*k+1], p[4*k+2], p[4*k+3]};
            e.be = (k % 16) == 15;
            e.me = (k == nw - 1);
            if (n == 0)                              e.tag = "R6";
            else if (4*k + 3 >= p.size() - 8)        e.tag = (msgno == 0) ? "R4" : "R8";
            else if (extra && (k / 16) == nblk - 1)  e.tag = "R5";
            else if (4*k <= n && n <= 4*k + 3)       e.tag = "R2";
            else if (4*k > n)                        e.tag = "R3";
            else                                     e.tag = gap ? "R11" : "R1";
            exp_q.push_back(e);
        end
    endtask

    task automatic beat(input logic [7:0] d, input bit last, input bit nob);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_last   = last;
        in_nobyte = nob;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_msg(input int msgno, input int gap_at);
        int n;
        n = msg_q.size();
        build_expected(msgno, gap_at >= 0);
        if (n == 0) beat(8'h00, 1'b1, 1'b1);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) beat(8'hFF, 1'b0, 1'b1);
            beat(msg_q[i], i == n - 1, 1'b0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #1;
        check(!in_ready, "R10", "in_ready after last beat", 64'(in_ready), 64'd0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic make_msg(input int len, input int seed);
        msg_q.delete();
        for (int i = 0; i < len; i++) msg_q.push_back(8'(i * 7 + seed));
    endtask

    // Output monitor: drive out_ready, then compare every handshake.
    always @(negedge clk) begin
        if (!rst) begin
            out_ready = bp_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (held)
                check(out_valid && {out_word, out_blk_end, out_msg_end} == held_v,
                      "R9", "held word changed", 64'({out_valid, out_word, out_blk_end, out_msg_end}),
                      64'({1'b1, held_v}));
            held   = out_valid && !out_ready;
            held_v = {out_word, out_blk_end, out_msg_end};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected output word", 64'(out_word), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_word == e.w, e.tag, "word", 64'(out_word), 64'(e.w));
                    check(out_blk_end == e.be && out_msg_end == e.me, "R7", "flags",
                          64'({out_blk_end, out_msg_end}), 64'({e.be, e.me}));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R9 watchdog expired, pending words actual=%0d expected=0", exp_q.size());
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(!out_valid, "R12", "out_valid in reset", 64'(out_valid), 64'd0);
        check(in_ready, "R12", "in_ready in reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst = 1'b0;

        msg_q = '{8'h61, 8'h62, 8'h63};
        send_msg(0, -1);
        make_msg(0, 0);   send_msg(1, -1);
        make_msg(55, 3);  send_msg(2, -1);
        make_msg(56, 5);  send_msg(3, -1);
        make_msg(63, 9);  send_msg(4, 20);
        make_msg(64, 11); send_msg(5, 10);
        bp_mode = 1'b1;
        make_msg(119, 13); send_msg(6, -1);
        make_msg(120, 17); send_msg(7, 1);
        make_msg(200, 19); send_msg(8, 77);
        make_msg(0, 0);    send_msg(9, -1);
        make_msg(3, 23);   send_msg(10, -1);

        check(exp_q.size() == 0, "R7", "words left over", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule